// File: doc/BRIEF.md
# UART Interrupt Event Status Unit

This unit gathers the interrupt-worthy events of a UART into one sticky status word. Every received character is compared against four programmable match registers, and each one can be switched off on its own. The four modem-control lines are synchronised, and any change of level on them is recorded. The unit also records the completion of the final byte of a transmit buffer. A receive-buffer-close event is raised by any of five receive conditions.

Software reads the status word through a small register port and clears bits by writing ones to them. A mask register selects which status bits drive the single interrupt output. The serial shifters, the baud generation, the buffer handling and the enables of the bits themselves lie outside this unit.

Top module: `uart_evt_status`

## Requirements
- R1: After reset, the status word, the mask register and all four match registers read as zero, and `irq` is low.
- R2: A read of the status word (address 0) places the status in bits 11 down to 2 and returns zero in bits 1:0 and in every bit above 11. The mask register (address 1) keeps only bits 11:2 and reads zero elsewhere.
- R3: A write to address 0 clears each status bit whose data bit is 1. A data bit of 0 leaves its status bit as it was. With no event and no clearing write, a status bit keeps its value.
- R4: Match register n sits at address 2+n and holds the compare character in bits CHAR_W-1:0 and an enable in bit 15. Status bit 8+n sets when `rx_valid` is high, the enable is 1 and `rx_char` equals the stored character. A disabled register never sets its bit.
- R5: Any change of level, rising or falling, on a modem line sets its status bit: DSR sets bit 7, DCD sets bit 6, CTS sets bit 5 and RI sets bit 4. The bit becomes readable after the third rising clock edge that follows the change (with SYNC_STAGES=2). One change produces exactly one set event.
- R6: A pulse on `tx_last_done` sets status bit 3 (transmit buffer closed).
- R7: Status bit 2 (receive buffer closed) sets on any of five conditions: a character match, `rx_gap_tmo`, `rx_break`, `rx_frame_err` together with `rx_valid`, or `rx_parity_err` together with `rx_valid`. An error-free character that matches nothing leaves it clear.
- R8: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when at least one status bit is 1 and the mask bit at the same position is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for `bus_addr` (combinational) |
| rx_valid | input | 1 | Strobe for one received character |
| rx_char | input | CHAR_W | Received character |
| rx_frame_err | input | 1 | Framing error on the strobed character |
| rx_parity_err | input | 1 | Parity error on the strobed character |
| rx_gap_tmo | input | 1 | Pulse for a character gap timeout |
| rx_break | input | 1 | Pulse for a detected line break |
| tx_last_done | input | 1 | Pulse when the final byte of a transmit buffer has been sent |
| line_dsr | input | 1 | Raw DSR modem input |
| line_dcd | input | 1 | Raw DCD modem input |
| line_cts | input | 1 | Raw CTS modem input |
| line_ri | input | 1 | Raw RI modem input |
| irq | output | 1 | Masked interrupt request |

## Verification
All state in the unit can be read back through the register port. A stuck or wrongly cleared status bit therefore appears at `bus_rdata` on the first read after the edge that should have changed it, and it also appears on `irq` in that same cycle once the mask bit is set. A wrong match comparator shows up as a misplaced bit among 11:8, or as a missing bit 2, right after the character strobe. A wrong synchroniser depth or a repeated edge shows up as a modem bit that appears one cycle early or late, or that comes back after it has been cleared.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
   // status word layout (positions are decoded by software)
   localparam int ST_LO     = 2;
   localparam int ST_HI     = 11;
   localparam int ST_W      = ST_HI - ST_LO + 1;
   localparam int ST_RBC    = 2;
   localparam int ST_TBC    = 3;
   localparam int ST_MODEM0 = 4;   // RI, CTS, DCD, DSR upward
   localparam int ST_MATCH0 = 8;
   localparam int NUM_MODEM = 4;
   localparam int NUM_MATCH = 4;

   // register word addresses
   localparam int ADR_STATUS = 0;
   localparam int ADR_MASK   = 1;
   localparam int ADR_MATCH0 = 2;

   // bit inside a match register that enables it
   localparam int MATCH_EN_BIT = 15;

   typedef logic [ST_W-1:0] stat_vec_t;

   // index of a status bit inside the packed vector
   function automatic int st_idx(input int pos);
      return pos - ST_LO;
   endfunction
endpackage

// File: rtl/uevt_modem_edge.sv
module uevt_modem_edge #(
   parameter int LINES       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_in,
   output logic [LINES-1:0] change
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("uevt_modem_edge: SYNC_STAGES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("uevt_modem_edge: LINES must be at least 1");
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      // SYNC_STAGES synchroniser flops plus one history flop
      logic [SYNC_STAGES:0] shift_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shift_q <= '0;
         else        shift_q <= {shift_q[SYNC_STAGES-1:0], raw_in[l]};
      end

      assign change[l] = shift_q[SYNC_STAGES] ^ shift_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/uevt_match_bank.sv
module uevt_match_bank #(
   parameter int NUM    = 4,
   parameter int CHAR_W = 8,
   parameter int DATA_W = 32,
   parameter int EN_BIT = 15
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM-1:0]             wr_sel,
   input  logic [DATA_W-1:0]          wdata,
   input  logic                       rx_valid,
   input  logic [CHAR_W-1:0]          rx_char,
   output logic [NUM-1:0]             hit,
   output logic [NUM-1:0][DATA_W-1:0] rd_word
);
   if (EN_BIT < CHAR_W || EN_BIT >= DATA_W) begin : g_bad_en
      $error("uevt_match_bank: EN_BIT must lie above the character and inside the word");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   for (genvar i = 0; i < NUM; i++) begin : g_cmp
      logic [CHAR_W-1:0] char_q;
      logic              en_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            char_q <= '0;
            en_q   <= 1'b0;
         end else if (wr_sel[i]) begin
            char_q <= wdata[CHAR_W-1:0];
            en_q   <= wdata[EN_BIT];
         end
      end

      assign hit[i] = rx_valid & en_q & (rx_char == char_q);

      always_comb begin
         rd_word[i]              = '0;
         rd_word[i][CHAR_W-1:0]  = char_q;
         rd_word[i][EN_BIT]      = en_q;
      end
   end
endmodule

// File: rtl/uevt_sticky_bits.sv
module uevt_sticky_bits #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_evt,
   input  logic [W-1:0] clr_req,
   output logic [W-1:0] q
);
   // a set in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_req) | set_evt;
   end
endmodule

// File: rtl/uart_evt_status.sv
module uart_evt_status
   import uart_evt_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 32,
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              rx_frame_err,
   input  logic              rx_parity_err,
   input  logic              rx_gap_tmo,
   input  logic              rx_break,
   input  logic              tx_last_done,
   input  logic              line_dsr,
   input  logic              line_dcd,
   input  logic              line_cts,
   input  logic              line_ri,
   output logic              irq
);
   localparam int NUM_REGS = ADR_MATCH0 + NUM_MATCH;

   if (DATA_W <= MATCH_EN_BIT || DATA_W <= ST_HI) begin : g_bad_data
      $error("uart_evt_status: DATA_W too narrow for the register layout");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("uart_evt_status: ADDR_W cannot reach every register");
   end
   if (CHAR_W < 5 || CHAR_W > 9) begin : g_bad_char
      $error("uart_evt_status: CHAR_W must be 5 to 9");
   end

   // ---------------- address decode ----------------
   logic                 wr_status, wr_mask;
   logic [NUM_MATCH-1:0] wr_match;

   assign wr_status = bus_wr && (bus_addr == ADDR_W'(ADR_STATUS));
   assign wr_mask   = bus_wr && (bus_addr == ADDR_W'(ADR_MASK));

   for (genvar i = 0; i < NUM_MATCH; i++) begin : g_dec
      assign wr_match[i] = bus_wr && (bus_addr == ADDR_W'(ADR_MATCH0 + i));
   end

   // ---------------- event sources ----------------
   logic [NUM_MATCH-1:0]             match_hit;
   logic [NUM_MATCH-1:0][DATA_W-1:0] match_word;
   logic [NUM_MODEM-1:0]             modem_chg;
   logic [NUM_MODEM-1:0]             modem_raw;

   // index 0 = RI ... index 3 = DSR, matching status bits 4..7
   assign modem_raw = {line_dsr, line_dcd, line_cts, line_ri};

   uevt_match_bank #(
      .NUM    (NUM_MATCH),
      .CHAR_W (CHAR_W),
      .DATA_W (DATA_W),
      .EN_BIT (MATCH_EN_BIT)
   ) match_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (wr_match),
      .wdata    (bus_wdata),
      .rx_valid (rx_valid),
      .rx_char  (rx_char),
      .hit      (match_hit),
      .rd_word  (match_word)
   );

   uevt_modem_edge #(
      .LINES       (NUM_MODEM),
      .SYNC_STAGES (SYNC_STAGES)
   ) modem_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (modem_raw),
      .change (modem_chg)
   );

   logic rbc_evt;
   assign rbc_evt = (|match_hit) | rx_gap_tmo | rx_break
                  | (rx_valid & (rx_frame_err | rx_parity_err));

   // ---------------- sticky status ----------------
   stat_vec_t set_vec, clr_vec, stat_q, mask_q;

   always_comb begin
      set_vec = '0;
      set_vec[st_idx(ST_RBC)] = rbc_evt;
      set_vec[st_idx(ST_TBC)] = tx_last_done;
      for (int m = 0; m < NUM_MODEM; m++) set_vec[st_idx(ST_MODEM0 + m)] = modem_chg[m];
      for (int k = 0; k < NUM_MATCH; k++) set_vec[st_idx(ST_MATCH0 + k)] = match_hit[k];
   end

   assign clr_vec = wr_status ? bus_wdata[ST_HI:ST_LO] : '0;

   uevt_sticky_bits #(.W(ST_W)) stat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_vec),
      .clr_req (clr_vec),
      .q       (stat_q)
   );

   // ---------------- mask ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= bus_wdata[ST_HI:ST_LO];
   end

   // ---------------- interrupt ----------------
   logic irq_raw;
   assign irq_raw = |(stat_q & mask_q);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_STATUS)) bus_rdata[ST_HI:ST_LO] = stat_q;
      if (bus_addr == ADDR_W'(ADR_MASK))   bus_rdata[ST_HI:ST_LO] = mask_q;
      for (int k = 0; k < NUM_MATCH; k++) begin
         if (bus_addr == ADDR_W'(ADR_MATCH0 + k)) bus_rdata = match_word[k];
      end
   end
endmodule

// File: rtl/uevt_status_chk.sv
module uevt_status_chk
   import uart_evt_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              tx_last_done,
   input logic              rx_gap_tmo,
   input logic              rx_break,
   input stat_vec_t         stat_q
);
   localparam int TBC_I = ST_TBC - ST_LO;
   localparam int RBC_I = ST_RBC - ST_LO;

   logic clr_tbc;
   assign clr_tbc = bus_wr && (bus_addr == ADDR_W'(ADR_STATUS)) && bus_wdata[ST_TBC];

   AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ADR_STATUS)) |-> (bus_rdata[ST_LO-1:0] == '0 && bus_rdata[DATA_W-1:ST_HI+1] == '0)); // R2

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tbc && !tx_last_done) |=> !stat_q[TBC_I]); // R3

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[TBC_I] && !clr_tbc) |=> stat_q[TBC_I]); // R3

   AST_TBC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last_done |=> stat_q[TBC_I]); // R6

   AST_RBC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_gap_tmo || rx_break) |=> stat_q[RBC_I]); // R7

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_last_done && clr_tbc) |=> stat_q[TBC_I]); // R8
endmodule

bind uart_evt_status uevt_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .tx_last_done (tx_last_done),
   .rx_gap_tmo   (rx_gap_tmo),
   .rx_break     (rx_break),
   .stat_q       (stat_q)
);

// File: tb/uart_evt_status_tb_top.sv
`timescale 1ns/100ps
module uart_evt_status_tb_top;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 32;
   localparam int CHAR_W = 8;
   localparam logic [DATA_W-1:0] EN = 32'h0000_8000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              rx_valid = 1'b0;
   logic [CHAR_W-1:0] rx_char = '0;
   logic              rx_frame_err = 1'b0;
   logic              rx_parity_err = 1'b0;
   logic              rx_gap_tmo = 1'b0;
   logic              rx_break = 1'b0;
   logic              tx_last_done = 1'b0;
   logic              line_dsr = 1'b0;
   logic              line_dcd = 1'b0;
   logic              line_cts = 1'b0;
   logic              line_ri = 1'b0;
   logic              irq;

   always #2 clk = ~clk;   // 250 MHz

   uart_evt_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
      .rx_char(rx_char), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
      .rx_gap_tmo(rx_gap_tmo), .rx_break(rx_break), .tx_last_done(tx_last_done),
      .line_dsr(line_dsr), .line_dcd(line_dcd), .line_cts(line_cts),
      .line_ri(line_ri), .irq(irq)
   );

   // ---------------- scoreboard ----------------
   typedef struct {
      bit                is_irq;
      logic [DATA_W-1:0] exp;
      string             tag;
   } item_t;

   item_t q[$];
   int    n_checks = 0;
   int    n_fail   = 0;
   logic  mon_go   = 1'b0;

   // monitor: pops one expected item per request, samples mid-cycle
   initial begin
      forever begin
         @(posedge mon_go);
         #0.2;
         if (q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: monitor request with empty queue");
         end else begin
            item_t it;
            logic [DATA_W-1:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {{(DATA_W-1){1'b0}}, irq} : bus_rdata;
            n_checks++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      q.push_back(it);
      mon_go = 1'b1;
      #0.5 mon_go = 1'b0;
   endtask

   task automatic expect_irq(input logic e, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {{(DATA_W-1){1'b0}}, e}; it.tag = tag;
      q.push_back(it);
      mon_go = 1'b1;
      #0.5 mon_go = 1'b0;
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rx(input logic [CHAR_W-1:0] c, input logic fe, input logic pe);
      @(negedge clk);
      rx_valid = 1'b1; rx_char = c; rx_frame_err = fe; rx_parity_err = pe;
      @(negedge clk);
      rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_all();
      wr(3'd0, 32'h0000_0FFC);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      idle(3);
      rst_n = 1'b1;

      // R1: reset values
      expect_reg(3'd0, 32'h0, "R1 status after reset");
      expect_reg(3'd1, 32'h0, "R1 mask after reset");
      expect_reg(3'd2, 32'h0, "R1 match0 after reset");
      expect_reg(3'd5, 32'h0, "R1 match3 after reset");
      expect_irq(1'b0, "R1 irq after reset");

      // R2: padding bits of mask and status
      wr(3'd1, 32'hFFFF_FFFF);
      expect_reg(3'd1, 32'h0000_0FFC, "R2 mask keeps bits 11:2 only");
      wr(3'd1, 32'h0);
      wr(3'd0, 32'hFFFF_FFFF);
      expect_reg(3'd0, 32'h0, "R2 status pad and clear-on-empty");

      // R4: match registers, enable bit 15
      wr(3'd2, EN | 32'h41);
      wr(3'd3, EN | 32'h42);
      wr(3'd4, 32'h43);            // disabled
      wr(3'd5, EN | 32'h41);
      expect_reg(3'd2, 32'h0000_8041, "R4 match0 readback");
      expect_reg(3'd4, 32'h0000_0043, "R4 match2 readback disabled");
      rx(8'h41, 1'b0, 1'b0);
      expect_reg(3'd0, 32'h0000_0904, "R4 R7 char 0x41 hits match0 and match3");
      clear_all();
      rx(8'h43, 1'b0, 1'b0);
      expect_reg(3'd0, 32'h0, "R4 disabled match2 never hits");
      rx(8'h42, 1'b0, 1'b0);
      expect_reg(3'd0, 32'h0000_0204, "R4 char 0x42 hits match1");

      // R3: write-one-to-clear per bit
      wr(3'd0, 32'h0000_0004);
      expect_reg(3'd0, 32'h0000_0200, "R3 clear bit 2 only");
      wr(3'd0, 32'h0);
      expect_reg(3'd0, 32'h0000_0200, "R3 zero write leaves bits");
      wr(3'd0, 32'h0000_0200);
      expect_reg(3'd0, 32'h0, "R3 clear bit 9");

      // R7: receive buffer close sources
      @(negedge clk); rx_gap_tmo = 1'b1; @(negedge clk); rx_gap_tmo = 1'b0;
      expect_reg(3'd0, 32'h0000_0004, "R7 gap timeout");
      clear_all();
      @(negedge clk); rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
      expect_reg(3'd0, 32'h0000_0004, "R7 line break");
      clear_all();
      rx(8'h55, 1'b1, 1'b0);
      expect_reg(3'd0, 32'h0000_0004, "R7 framing error");
      clear_all();
      rx(8'h55, 1'b0, 1'b1);
      expect_reg(3'd0, 32'h0000_0004, "R7 parity error");
      clear_all();
      rx(8'h55, 1'b0, 1'b0);
      expect_reg(3'd0, 32'h0, "R7 clean unmatched char");

      // R6: transmit buffer close
      @(negedge clk); tx_last_done = 1'b1; @(negedge clk); tx_last_done = 1'b0;
      expect_reg(3'd0, 32'h0000_0008, "R6 last byte sent");
      clear_all();

      // R5: CTS rising edge, latency of three edges
      @(negedge clk); line_cts = 1'b1;
      expect_reg(3'd0, 32'h0, "R5 cts not yet after 1 edge");
      expect_reg(3'd0, 32'h0, "R5 cts not yet after 2 edges");
      expect_reg(3'd0, 32'h0000_0020, "R5 cts after 3 edges");
      clear_all();
      idle(5);
      expect_reg(3'd0, 32'h0, "R5 cts one event per change");
      // falling edge on CTS
      @(negedge clk); line_cts = 1'b0;
      idle(4);
      expect_reg(3'd0, 32'h0000_0020, "R5 cts falling edge");
      clear_all();
      @(negedge clk); line_dsr = 1'b1;
      idle(4);
      expect_reg(3'd0, 32'h0000_0080, "R5 dsr change");
      clear_all();
      @(negedge clk); line_dcd = 1'b1;
      idle(4);
      expect_reg(3'd0, 32'h0000_0040, "R5 dcd change");
      clear_all();
      @(negedge clk); line_ri = 1'b1;
      idle(4);
      expect_reg(3'd0, 32'h0000_0010, "R5 ri change");
      clear_all();

      // R8: set and clear in the same cycle
      @(negedge clk);
      tx_last_done = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0000_0008;
      @(negedge clk);
      tx_last_done = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      expect_reg(3'd0, 32'h0000_0008, "R8 set beats clear");

      // R9: masked interrupt
      expect_irq(1'b0, "R9 irq low with mask zero");
      wr(3'd1, 32'h0000_0008);
      expect_irq(1'b1, "R9 irq with TBC unmasked");
      wr(3'd1, 32'h0000_0004);
      expect_irq(1'b0, "R9 irq low when other bit masked");
      wr(3'd1, 32'h0000_0008);
      wr(3'd0, 32'h0000_0008);
      expect_irq(1'b0, "R9 irq drops after clear");

      idle(2);
      if (q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   // watchdog
   initial begin
      #400000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule